// File: doc/BRIEF.md
# Parameterized XNOR LFSR Counter

This block is a pseudo-random counter made of a left-shifting register. On every enabled clock edge the stored word moves one place toward the most significant bit. A feedback bit enters at bit 0. That bit is the inverted parity (XNOR) of a fixed set of tap bits. The tap set is picked when the design is elaborated, from the width parameter, and each supported width uses a maximum-length set. For a width of N, one run covers 2^N - 1 distinct words before the register returns to its starting word. Any width other than 4, 8, 16 or 32 stops elaboration with an error.

A synchronous seed-load strobe places a seed word in the register, and it overrides the step enable. A combinational flag is high whenever the register equals the seed word currently on the input. If the seed is held steady, the flag therefore marks the start and the end of every run. Because the feedback is XNOR, the all-ones word is the lock-up state. No run that starts from any other word reaches it, but if all-ones is loaded the register stays there. A synchronous active-high reset clears the register to zero.

Top module: `xnor_lfsr`

## Requirements
- R1: On a clock edge with reset low, load low and enable high, every register bit moves up one place and bit 0 takes the XNOR of the tap bits. The zero-indexed taps are: width 4 → 3,2; width 8 → 7,5,4,3; width 16 → 15,14,12,3; width 32 → 31,21,1,0.
- R2: For width 4, starting from 0 with enable held high, the output follows 0,1,3,7,14,13,11,6,12,9,2,5,10,4,8 and then returns to 0.
- R3: When load is high and reset is low, the register takes the seed word on that edge, whatever the enable does.
- R4: With reset, load and enable all low, the register keeps its value.
- R5: The done flag is combinational and is high exactly when the register equals the present seed input. A change of the seed alone changes the flag without a clock edge.
- R6: For widths 4, 8 and 16, the run that starts from 0 visits every word except all-ones exactly once in its first 2^N - 1 steps, and returns to 0 after exactly 2^N - 1 steps. With the seed held at 0, done returns high for the first time after exactly 2^N - 1 steps.
- R7: When all-ones is loaded, the register stays all-ones for every following enabled step.
- R8: A synchronous active-high reset clears the register to zero on the next edge and takes priority over load and enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset to zero |
| step_en | input | 1 | Advance the sequence by one step |
| seed_load | input | 1 | Load seed_word on this edge (overrides step_en) |
| seed_word | input | WIDTH | Seed value, also the compare value for run_done |
| state_out | output | WIDTH | Current register value |
| run_done | output | 1 | High while state_out equals seed_word |

## Verification
Every state is visible at the port, so a wrong feedback bit appears as a wrong word on the edge right after the faulty step. A reference model compares that word on every clock and catches the error within one cycle. A wrong tap set can still produce plausible-looking words. It shows up as a repeated word or a run that is too short or too long, and the duplicate and period checks catch it within one run. A fault in the priority between load and enable, or a register that fails to hold, shows up one edge after the control pattern that exposes it. A fault in the compare logic shows on run_done as soon as the seed input changes.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    // Maximum supported register width for the tap table
    localparam int MAX_WIDTH = 64;

    // Zero-indexed tap positions encoded as a bit mask, per supported width
    function automatic logic [MAX_WIDTH-1:0] tap_mask(input int width);
        logic [MAX_WIDTH-1:0] m;
        m = '0;
        case (width)
            4:  m[3:0]  = 4'b1100;
            8:  m[7:0]  = 8'hB8;
            16: m[15:0] = 16'hD008;
            32: m[31:0] = 32'h8020_0003;
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic bit width_supported(input int width);
        return (width == 4) || (width == 8) || (width == 16) || (width == 32);
    endfunction

endpackage

// File: rtl/lfsr_feedback.sv
// Inverted parity over the tapped bits of the register
module lfsr_feedback #(
    parameter int               WIDTH    = 4,
    parameter logic [WIDTH-1:0] TAP_MASK = '0
) (
    input  logic [WIDTH-1:0] state_in,
    output logic             fb_bit
);
    logic [WIDTH-1:0] tapped;

    for (genvar i = 0; i < WIDTH; i++) begin : g_tap
        assign tapped[i] = state_in[i] & TAP_MASK[i];
    end

    assign fb_bit = ~(^tapped);
endmodule

// File: rtl/lfsr_seed_match.sv
// Bitwise equality between the register and the live seed word
module lfsr_seed_match #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    output logic             equal
);
    logic [WIDTH-1:0] bit_eq;

    for (genvar i = 0; i < WIDTH; i++) begin : g_eq
        assign bit_eq[i] = ~(lhs[i] ^ rhs[i]);
    end

    assign equal = &bit_eq;
endmodule

// File: rtl/xnor_lfsr.sv
module xnor_lfsr #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             seed_load,
    input  logic [WIDTH-1:0] seed_word,
    output logic [WIDTH-1:0] state_out,
    output logic             run_done
);
    localparam logic [lfsr_pkg::MAX_WIDTH-1:0] TAP_ALL = lfsr_pkg::tap_mask(WIDTH);
    localparam logic [WIDTH-1:0]               TAPS    = TAP_ALL[WIDTH-1:0];

    if (!lfsr_pkg::width_supported(WIDTH)) begin : g_bad_width
        $error("xnor_lfsr: WIDTH %0d has no maximum-length tap set", WIDTH);
    end

    typedef struct packed {
        logic [WIDTH-1:0] shreg;
    } lfsr_state_t;

    lfsr_state_t cur_q;
    lfsr_state_t nxt_d;
    logic        fb_d;
    logic        match_d;

    lfsr_feedback #(
        .WIDTH   (WIDTH),
        .TAP_MASK(TAPS)
    ) u_feedback (
        .state_in(cur_q.shreg),
        .fb_bit  (fb_d)
    );

    lfsr_seed_match #(
        .WIDTH(WIDTH)
    ) u_match (
        .lhs  (cur_q.shreg),
        .rhs  (seed_word),
        .equal(match_d)
    );

    always_comb begin
        nxt_d = cur_q;
        if (rst) begin
            nxt_d.shreg = '0;
        end else if (seed_load) begin
            nxt_d.shreg = seed_word;
        end else if (step_en) begin
            nxt_d.shreg = {cur_q.shreg[WIDTH-2:0], fb_d};
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign state_out = cur_q.shreg;
    assign run_done  = match_d;
endmodule

// File: rtl/xnor_lfsr_checker.sv
module xnor_lfsr_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             step_en,
    input logic             seed_load,
    input logic [WIDTH-1:0] seed_word,
    input logic [WIDTH-1:0] state_out,
    input logic             run_done
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (state_out == '0)); // R8

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> (state_out == $past(seed_word))); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!seed_load && !step_en) |=> $stable(state_out)); // R4

    AST_SHIFT_UP: assert property (@(posedge clk) disable iff (rst)
        (!seed_load && step_en) |=> (state_out[WIDTH-1:1] == $past(state_out[WIDTH-2:0]))); // R1

    AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        seed_load ##1 $stable(seed_word) |-> run_done); // R5

    AST_ONES_LOCK: assert property (@(posedge clk) disable iff (rst)
        (!seed_load && (state_out == '1)) |=> (state_out == '1)); // R7
endmodule

bind xnor_lfsr xnor_lfsr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .step_en  (step_en),
    .seed_load(seed_load),
    .seed_word(seed_word),
    .state_out(state_out),
    .run_done (run_done)
);

// File: tb/xnor_lfsr_bench.sv
`timescale 1ns/1ps
module xnor_lfsr_bench;
    localparam time T = 20ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        load = 1'b0;
    logic [31:0] seed = '0;
    logic [3:0]  s4;
    logic [7:0]  s8;
    logic [15:0] s16;
    logic [31:0] s32;
    logic        d4, d8, d16, d32;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;
    bit finished = 1'b0;

    always #(T/2) clk = ~clk;

    xnor_lfsr #(.WIDTH(4))  u_xnor_lfsr   (.clk(clk), .rst(rst), .step_en(en), .seed_load(load),
                                           .seed_word(seed[3:0]),  .state_out(s4),  .run_done(d4));
    xnor_lfsr #(.WIDTH(8))  u_xnor_lfsr8  (.clk(clk), .rst(rst), .step_en(en), .seed_load(load),
                                           .seed_word(seed[7:0]),  .state_out(s8),  .run_done(d8));
    xnor_lfsr #(.WIDTH(16)) u_xnor_lfsr16 (.clk(clk), .rst(rst), .step_en(en), .seed_load(load),
                                           .seed_word(seed[15:0]), .state_out(s16), .run_done(d16));
    xnor_lfsr #(.WIDTH(32)) u_xnor_lfsr32 (.clk(clk), .rst(rst), .step_en(en), .seed_load(load),
                                           .seed_word(seed),       .state_out(s32), .run_done(d32));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [31:0] wmask(input int w);
        return (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    endfunction

    // Behavioural step: 1-indexed tap lists, XNOR of listed bits shifted in at the bottom
    function automatic logic [31:0] mstep(input logic [31:0] s, input int w);
        int taps[$];
        logic x;
        case (w)
            4:  taps = '{4, 3};
            8:  taps = '{8, 6, 5, 4};
            16: taps = '{16, 15, 13, 4};
            default: taps = '{32, 22, 2, 1};
        endcase
        x = 1'b0;
        foreach (taps[i]) x = x ^ s[taps[i]-1];
        x = ~x;
        return ((s << 1) | {31'd0, x}) & wmask(w);
    endfunction

    logic [31:0] m4, m8, m16, m32;

    always @(posedge clk) begin
        if (rst) begin
            m4 <= '0; m8 <= '0; m16 <= '0; m32 <= '0;
        end else if (load) begin
            m4 <= seed & wmask(4); m8 <= seed & wmask(8);
            m16 <= seed & wmask(16); m32 <= seed;
        end else if (en) begin
            m4 <= mstep(m4, 4); m8 <= mstep(m8, 8);
            m16 <= mstep(m16, 16); m32 <= mstep(m32, 32);
        end
    end

    // Reference comparison on every clock, away from the active edge (R1, R5)
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(s4 == m4[3:0],   "R1 w4 state",  {28'd0, s4}, m4);
            chk(s8 == m8[7:0],   "R1 w8 state",  {24'd0, s8}, m8);
            chk(s16 == m16[15:0], "R1 w16 state", {16'd0, s16}, m16);
            chk(s32 == m32,      "R1 w32 state", s32, m32);
            chk(d4 == (m4 == (seed & wmask(4))),    "R5 w4 done",  {31'd0, d4}, 32'(m4 == (seed & wmask(4))));
            chk(d16 == (m16 == (seed & wmask(16))), "R5 w16 done", {31'd0, d16}, 32'(m16 == (seed & wmask(16))));
            chk(d32 == (m32 == seed),               "R5 w32 done", {31'd0, d32}, 32'(m32 == seed));
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(T * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    bit seen4[16];
    bit seen8[256];
    bit seen16[65536];

    initial begin : main
        int exp4[15] = '{0, 1, 3, 7, 14, 13, 11, 6, 12, 9, 2, 5, 10, 4, 8};
        int dup4 = 0, dup8 = 0, dup16 = 0;
        int ones4 = 0, ones8 = 0, ones16 = 0;
        int first4 = 0, first8 = 0, first16 = 0;
        logic [31:0] hold4, hold16, hold32;

        // R8: reset with load and enable active still clears to zero
        rst = 1'b1; load = 1'b1; en = 1'b1; seed = 32'hFFFF_FFFF;
        tick();
        cmp_on = 1'b1;
        tick();
        @(negedge clk);
        chk(s4 == 4'd0 && s8 == 8'd0, "R8 reset beats load", {24'd0, s8}, 32'd0);
        chk(s16 == 16'd0 && s32 == 32'd0, "R8 reset clears", s32, 32'd0);

        load = 1'b0; seed = '0;
        tick();
        rst = 1'b0; en = 1'b1;

        // R2 and R6: one full sweep from zero, seed held at zero
        for (int k = 0; k <= 65535; k++) begin
            @(negedge clk);
            if (k < 15) chk(s4 == exp4[k][3:0], "R2 sequence", {28'd0, s4}, 32'(exp4[k]));
            if (k == 15) chk(s4 == 4'd0, "R2 wraps to 0", {28'd0, s4}, 32'd0);
            if (k < 15) begin
                if (seen4[s4]) dup4++;
                if (s4 == 4'hF) ones4++;
                seen4[s4] = 1'b1;
            end
            if (k < 255) begin
                if (seen8[s8]) dup8++;
                if (s8 == 8'hFF) ones8++;
                seen8[s8] = 1'b1;
            end
            if (k < 65535) begin
                if (seen16[s16]) dup16++;
                if (s16 == 16'hFFFF) ones16++;
                seen16[s16] = 1'b1;
            end
            if (k > 0 && d4 && first4 == 0) first4 = k;
            if (k > 0 && d8 && first8 == 0) first8 = k;
            if (k > 0 && d16 && first16 == 0) first16 = k;
            if (k == 255) chk(s8 == 8'd0, "R6 w8 returns", {24'd0, s8}, 32'd0);
            if (k == 65535) chk(s16 == 16'd0, "R6 w16 returns", {16'd0, s16}, 32'd0);
            tick();
        end
        chk(dup4 == 0 && ones4 == 0, "R6 w4 unique", 32'(dup4 + ones4), 32'd0);
        chk(dup8 == 0 && ones8 == 0, "R6 w8 unique", 32'(dup8 + ones8), 32'd0);
        chk(dup16 == 0 && ones16 == 0, "R6 w16 unique", 32'(dup16 + ones16), 32'd0);
        chk(first4 == 15, "R6 w4 done period", 32'(first4), 32'd15);
        chk(first8 == 255, "R6 w8 done period", 32'(first8), 32'd255);
        chk(first16 == 65535, "R6 w16 done period", 32'(first16), 32'd65535);

        // R4: hold with enable and load low
        en = 1'b0;
        @(negedge clk);
        hold4 = {28'd0, s4}; hold16 = {16'd0, s16}; hold32 = s32;
        for (int k = 0; k < 4; k++) begin
            tick();
            @(negedge clk);
            chk({28'd0, s4} == hold4 && {16'd0, s16} == hold16, "R4 hold", {16'd0, s16}, hold16);
            chk(s32 == hold32, "R4 hold w32", s32, hold32);
        end

        // R3: load wins over enable; R5: done high right after load
        tick();
        seed = 32'hA5C3_9E17; load = 1'b1; en = 1'b1;
        tick();
        load = 1'b0; en = 1'b0;
        @(negedge clk);
        chk(s4 == 4'h7 && s8 == 8'h17, "R3 load w4/w8", {24'd0, s8}, 32'h17);
        chk(s16 == 16'h9E17 && s32 == 32'hA5C3_9E17, "R3 load w16/w32", s32, 32'hA5C3_9E17);
        chk(d4 && d8 && d16 && d32, "R5 done after load", {28'd0, d4, d8, d16, d32}, 32'hF);

        // R5: seed change alone drops done with no edge
        seed = 32'h0000_0001;
        #1;
        chk(!d4 && !d32, "R5 live seed compare", {30'd0, d4, d32}, 32'd0);
        seed = 32'hA5C3_9E17;
        #1;
        chk(d16, "R5 seed restored", {31'd0, d16}, 32'd1);

        // R7: all-ones lock
        tick();
        seed = 32'hFFFF_FFFF; load = 1'b1;
        tick();
        load = 1'b0; en = 1'b1;
        for (int k = 0; k < 8; k++) begin
            tick();
            @(negedge clk);
            chk(s4 == 4'hF && s8 == 8'hFF, "R7 ones lock w4/w8", {24'd0, s8}, 32'hFF);
            chk(s16 == 16'hFFFF && s32 == 32'hFFFF_FFFF, "R7 ones lock w16/w32", s32, 32'hFFFF_FFFF);
        end

        // R8: reset mid-run
        tick();
        rst = 1'b1;
        tick();
        @(negedge clk);
        chk(s32 == 32'd0 && s4 == 4'd0, "R8 mid-run reset", s32, 32'd0);
        tick();
        rst = 1'b0; seed = 32'h0000_0001; load = 1'b1;
        tick();
        load = 1'b0;
        for (int k = 0; k < 300; k++) tick();

        @(negedge clk);
        finish_run();
    end
endmodule